// File: doc/BRIEF.md
# Scanline Player with Pixel Stretch and Line Repeat

This block sits between a line generator and a video output. The generator writes the next scanline of 8-bit pixels into a working buffer while the block plays the current line out of a separate scanout buffer. When the timing logic strobes the start of horizontal blanking, the block transfers the working buffer into the scanout buffer in a single clock. In the same clock it captures a line descriptor with four fields: a signed start offset, a pixel count, extra hold clocks per pixel, and a count of later scanlines that reuse the line.

During blanking, a small engine works out where the line stands when active video begins. A negative offset moves the line left, so its first pixels fall before the visible area. When the active-video strobe arrives, a sequencer drives one pixel per clock. Each stored pixel stays on the output for the pixel-clock divider plus its stretch value. Clocks outside the described span are driven black.

A line with a nonzero repeat count is replayed on that many following scanlines. No transfer takes place on those scanlines and no new line is requested. With these controls, a one-pixel line stretched across the full width and repeated fills the screen with one colour.

Top module: `scanline_player`

## Requirements
- R1: After reset, `pix_out`, `de_out` and `gen_req` are 0. The scanout buffer holds zeros and the latched pixel count is 0, so a line played before any transfer is all black.
- R2: Writes to the working buffer never change what is displayed. The working contents reach the scanout buffer only through a transfer. A transfer happens on an `hblank_start` strobe only when no repeat is pending.
- R3: The descriptor inputs are captured only at a transfer. A change to them at any other time, including during active video, takes effect at the next transfer.
- R4: Stored pixel i is output for PCLK_DIV + stretch consecutive clocks (4 clocks at stretch 0 with the default divider). Pixel 0 starts at active-video clock offset*PCLK_DIV when the offset is zero or positive.
- R5: Every clock of active video outside the described span is driven 0. While `de_out` is low, `pix_out` is 0.
- R6: With a negative offset, active-video clock x shows stored pixel (x - offset*PCLK_DIV) / (PCLK_DIV + stretch), using integer division. The pixels before that point are clipped.
- R7: Repeat count N: the N `hblank_start` strobes after a transfer perform no transfer and keep the descriptor, so the same line is replayed. The strobe after those N performs a transfer.
- R8: `gen_req` is high for exactly one clock, the clock after each `hblank_start` strobe that performed a transfer. It is low after a strobe that only replays.
- R9: Length 1 with stretch (ACTIVE_PIX-1)*PCLK_DIV shows stored pixel 0 on every clock of active video.
- R10: A pixel count above the buffer depth LINE_PIX is treated as LINE_PIX. Clocks past the last stored pixel are black.
- R11: `active_start` sampled high at edge E0 makes `de_out` high from edge E0+1 for exactly ACTIVE_PIX*PCLK_DIV clocks. `pix_out` for active clock x is valid in the same interval as `de_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Working-buffer write strobe |
| wr_addr | input | $clog2(LINE_PIX) | Working-buffer pixel index |
| wr_data | input | PIX_W | Pixel value to write |
| desc_offset | input | OFF_W | Signed start offset in output pixels |
| desc_length | input | DLEN_W | Stored pixel count |
| desc_stretch | input | STRETCH_W | Extra clocks each pixel is held |
| desc_repeat | input | REPEAT_W | Following scanlines that replay this line |
| hblank_start | input | 1 | One-clock strobe at the start of horizontal blanking |
| active_start | input | 1 | One-clock strobe at the start of active video |
| pix_out | output | PIX_W | Output pixel, 0 when black |
| de_out | output | 1 | High during active video |
| gen_req | output | 1 | Pulse asking the generator for the next line |

## Verification
The line is played with four kinds of descriptor:
- Zero offset, zero stretch, and a pixel count below the active width. This separates correct 4-clock pixels from the black tail.
- A positive offset with stretch. This confirms the leading black run and the longer hold per pixel.
- A negative offset. This shows whether the skip engine lands on the right pixel and the right phase within it.
- A one-pixel line stretched across the full width. This is the solid fill.

Further scenarios check the timing rules:
- Working-buffer writes and descriptor changes made between transfers. These show whether anything leaks into the displayed line early.
- A repeat count of two followed by a fresh line. This shows whether replayed scanlines skip the transfer and the `gen_req` pulse.
- A line requested right after reset. This shows the reset state.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [1:0] {
      PREP_IDLE = 2'd0,
      PREP_LOAD = 2'd1,
      PREP_SKIP = 2'd2
   } prep_st_e;
endpackage

// File: rtl/sp_line_store.sv
module sp_line_store #(
   parameter int PIX_W = 8,
   parameter int DEPTH = 32,
   parameter int AW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [PIX_W-1:0] wr_data,
   input  logic             copy_en,
   input  logic [AW-1:0]    rd_idx,
   output logic [PIX_W-1:0] rd_data
);
   logic [DEPTH*PIX_W-1:0] scan_flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [PIX_W-1:0] work_q;
      logic [PIX_W-1:0] scan_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            work_q <= '0;
            scan_q <= '0;
         end else begin
            if (wr_en && (wr_addr == AW'(i))) work_q <= wr_data;
            if (copy_en) scan_q <= work_q;
         end
      end
      assign scan_flat[i*PIX_W +: PIX_W] = scan_q;
   end

   assign rd_data = scan_flat[rd_idx*PIX_W +: PIX_W];

   // R2
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_en |=> $stable(scan_flat));
endmodule

// File: rtl/sp_line_ctrl.sv
module sp_line_ctrl #(
   parameter int OFF_W     = 8,
   parameter int DLEN_W    = 8,
   parameter int STRETCH_W = 12,
   parameter int REPEAT_W  = 10,
   parameter int DEPTH     = 32,
   parameter int LEN_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hblank_start,
   input  logic [OFF_W-1:0]     desc_offset,
   input  logic [DLEN_W-1:0]    desc_length,
   input  logic [STRETCH_W-1:0] desc_stretch,
   input  logic [REPEAT_W-1:0]  desc_repeat,
   output logic                 copy_en,
   output logic                 prep_go,
   output logic                 gen_req,
   output logic [OFF_W-1:0]     off_q,
   output logic [LEN_W-1:0]     len_q,
   output logic [STRETCH_W-1:0] stretch_q
);
   logic [REPEAT_W-1:0] rpt_q;
   logic [LEN_W-1:0]    len_clamped;

   assign copy_en     = hblank_start && (rpt_q == '0);
   assign len_clamped = (desc_length > DLEN_W'(DEPTH)) ? LEN_W'(DEPTH)
                                                        : LEN_W'(desc_length);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpt_q     <= '0;
         off_q     <= '0;
         len_q     <= '0;
         stretch_q <= '0;
         gen_req   <= 1'b0;
         prep_go   <= 1'b0;
      end else begin
         gen_req <= copy_en;
         prep_go <= hblank_start;
         if (copy_en) begin
            rpt_q     <= desc_repeat;
            off_q     <= desc_offset;
            len_q     <= len_clamped;
            stretch_q <= desc_stretch;
         end else if (hblank_start) begin
            rpt_q <= rpt_q - REPEAT_W'(1);
         end
      end
   end

   // R8
   req_after_hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_req |-> $past(hblank_start));
   // R7
   replay_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hblank_start && rpt_q != '0) |=> !gen_req);
   // R3
   desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hblank_start |=> ($stable(off_q) && $stable(len_q) && $stable(stretch_q)));
endmodule

// File: rtl/sp_skip_prep.sv
module sp_skip_prep
   import sp_pkg::*;
#(
   parameter int PCLK_DIV  = 4,
   parameter int OFF_W     = 8,
   parameter int STRETCH_W = 12,
   parameter int SKIP_W    = 11,
   parameter int HOLD_W    = 13,
   parameter int CMP_W     = 13,
   parameter int IDX_W     = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [OFF_W-1:0]     off_q,
   input  logic [STRETCH_W-1:0] stretch_q,
   output logic [HOLD_W-1:0]    hold,
   output logic [IDX_W-1:0]     start_idx,
   output logic [HOLD_W-1:0]    start_phase,
   output logic [SKIP_W-1:0]    delay
);
   prep_st_e          st_q;
   logic [CMP_W-1:0]  skip_q;
   logic [SKIP_W-1:0] off_wide, mag, scaled;
   logic              neg;

   assign neg      = off_q[OFF_W-1];
   assign off_wide = {{(SKIP_W-OFF_W){off_q[OFF_W-1]}}, off_q};
   assign mag      = neg ? (~off_wide + SKIP_W'(1)) : off_wide;
   assign hold     = HOLD_W'(PCLK_DIV) + HOLD_W'(stretch_q);

   if ((PCLK_DIV & (PCLK_DIV - 1)) == 0) begin : g_scale_shift
      assign scaled = mag << $clog2(PCLK_DIV);
   end else begin : g_scale_mul
      assign scaled = mag * SKIP_W'(PCLK_DIV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PREP_IDLE;
         skip_q    <= '0;
         start_idx <= '0;
         delay     <= '0;
      end else if (go) begin
         st_q <= PREP_LOAD;
      end else begin
         unique case (st_q)
            PREP_LOAD: begin
               skip_q    <= neg ? CMP_W'(scaled) : '0;
               delay     <= neg ? '0 : scaled;
               start_idx <= '0;
               st_q      <= PREP_SKIP;
            end
            PREP_SKIP: begin
               if (skip_q >= CMP_W'(hold)) begin
                  skip_q    <= skip_q - CMP_W'(hold);
                  start_idx <= start_idx + IDX_W'(1);
               end else begin
                  st_q <= PREP_IDLE;
               end
            end
            default: st_q <= PREP_IDLE;
         endcase
      end
   end

   assign start_phase = HOLD_W'(skip_q);

   // R6
   phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PREP_IDLE) |-> (skip_q < CMP_W'(hold)));
endmodule

// File: rtl/sp_pixel_seq.sv
module sp_pixel_seq #(
   parameter int PIX_W       = 8,
   parameter int DEPTH       = 32,
   parameter int AW          = 5,
   parameter int ACTIVE_CLKS = 160,
   parameter int CLK_W       = 8,
   parameter int SKIP_W      = 11,
   parameter int HOLD_W      = 13,
   parameter int IDX_W       = 13,
   parameter int LEN_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_start,
   input  logic [HOLD_W-1:0] hold,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [HOLD_W-1:0] start_phase,
   input  logic [SKIP_W-1:0] delay,
   input  logic [LEN_W-1:0]  len_q,
   input  logic [PIX_W-1:0]  rd_data,
   output logic [AW-1:0]     rd_idx,
   output logic [PIX_W-1:0]  pix_out,
   output logic              de_out
);
   logic              active_q;
   logic [CLK_W-1:0]  left_q;
   logic [SKIP_W-1:0] dly_q;
   logic [IDX_W-1:0]  idx_q;
   logic [HOLD_W-1:0] phase_q;
   logic              in_span;
   logic [PIX_W-1:0]  pix_d;

   assign in_span = (dly_q == '0) && (idx_q < IDX_W'(len_q));
   assign rd_idx  = (idx_q < IDX_W'(DEPTH)) ? idx_q[AW-1:0] : '0;
   assign pix_d   = (active_q && in_span) ? rd_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         left_q   <= '0;
         dly_q    <= '0;
         idx_q    <= '0;
         phase_q  <= '0;
         pix_out  <= '0;
         de_out   <= 1'b0;
      end else begin
         pix_out <= pix_d;
         de_out  <= active_q;
         if (active_start) begin
            active_q <= 1'b1;
            left_q   <= CLK_W'(ACTIVE_CLKS);
            dly_q    <= delay;
            idx_q    <= start_idx;
            phase_q  <= start_phase;
         end else if (active_q) begin
            if (left_q == CLK_W'(1)) active_q <= 1'b0;
            left_q <= left_q - CLK_W'(1);
            if (dly_q != '0) begin
               dly_q <= dly_q - SKIP_W'(1);
            end else if (in_span) begin
               if (phase_q == hold - HOLD_W'(1)) begin
                  phase_q <= '0;
                  idx_q   <= idx_q + IDX_W'(1);
               end else begin
                  phase_q <= phase_q + HOLD_W'(1);
               end
            end
         end
      end
   end

   // R5
   black_off_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !de_out |-> (pix_out == '0));
   // R4
   lead_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !active_start && dly_q != '0) |=> (pix_out == '0));
   // R11
   de_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de_out) |-> $past(active_start, 2));
endmodule

// File: rtl/scanline_player.sv
module scanline_player #(
   parameter int PIX_W      = 8,
   parameter int LINE_PIX   = 32,
   parameter int ACTIVE_PIX = 40,
   parameter int PCLK_DIV   = 4,
   parameter int OFF_W      = 8,
   parameter int DLEN_W     = 8,
   parameter int STRETCH_W  = 12,
   parameter int REPEAT_W   = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [$clog2(LINE_PIX)-1:0] wr_addr,
   input  logic [PIX_W-1:0]            wr_data,
   input  logic [OFF_W-1:0]            desc_offset,
   input  logic [DLEN_W-1:0]           desc_length,
   input  logic [STRETCH_W-1:0]        desc_stretch,
   input  logic [REPEAT_W-1:0]         desc_repeat,
   input  logic                        hblank_start,
   input  logic                        active_start,
   output logic [PIX_W-1:0]            pix_out,
   output logic                        de_out,
   output logic                        gen_req
);
   localparam int AW          = $clog2(LINE_PIX);
   localparam int LEN_W       = $clog2(LINE_PIX + 1);
   localparam int ACTIVE_CLKS = ACTIVE_PIX * PCLK_DIV;
   localparam int CLK_W       = $clog2(ACTIVE_CLKS + 1);
   localparam int SKIP_W      = OFF_W + $clog2(PCLK_DIV) + 1;
   localparam int HOLD_W      = STRETCH_W + 1;
   localparam int CMP_W       = (SKIP_W > HOLD_W) ? SKIP_W : HOLD_W;
   localparam int IDX_W       = (CMP_W > LEN_W + 1) ? CMP_W : LEN_W + 1;

   if (LINE_PIX < 2) begin : g_bad_depth
      initial $fatal(1, "LINE_PIX must be at least 2");
   end
   if (PCLK_DIV < 1) begin : g_bad_div
      initial $fatal(1, "PCLK_DIV must be at least 1");
   end
   if (DLEN_W < LEN_W) begin : g_bad_len
      initial $fatal(1, "DLEN_W too narrow for LINE_PIX");
   end
   if (OFF_W < 2) begin : g_bad_off
      initial $fatal(1, "OFF_W must be at least 2");
   end

   logic                 copy_en, prep_go;
   logic [OFF_W-1:0]     off_q;
   logic [LEN_W-1:0]     len_q;
   logic [STRETCH_W-1:0] stretch_q;
   logic [HOLD_W-1:0]    hold, start_phase;
   logic [IDX_W-1:0]     start_idx;
   logic [SKIP_W-1:0]    delay;
   logic [AW-1:0]        rd_idx;
   logic [PIX_W-1:0]     rd_data;

   sp_line_store #(.PIX_W(PIX_W), .DEPTH(LINE_PIX), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .copy_en(copy_en), .rd_idx(rd_idx), .rd_data(rd_data));

   sp_line_ctrl #(.OFF_W(OFF_W), .DLEN_W(DLEN_W), .STRETCH_W(STRETCH_W),
                  .REPEAT_W(REPEAT_W), .DEPTH(LINE_PIX), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .hblank_start(hblank_start),
      .desc_offset(desc_offset), .desc_length(desc_length),
      .desc_stretch(desc_stretch), .desc_repeat(desc_repeat),
      .copy_en(copy_en), .prep_go(prep_go), .gen_req(gen_req),
      .off_q(off_q), .len_q(len_q), .stretch_q(stretch_q));

   sp_skip_prep #(.PCLK_DIV(PCLK_DIV), .OFF_W(OFF_W), .STRETCH_W(STRETCH_W),
                  .SKIP_W(SKIP_W), .HOLD_W(HOLD_W), .CMP_W(CMP_W),
                  .IDX_W(IDX_W)) u_prep (
      .clk(clk), .rst_n(rst_n), .go(prep_go), .off_q(off_q),
      .stretch_q(stretch_q), .hold(hold), .start_idx(start_idx),
      .start_phase(start_phase), .delay(delay));

   sp_pixel_seq #(.PIX_W(PIX_W), .DEPTH(LINE_PIX), .AW(AW),
                  .ACTIVE_CLKS(ACTIVE_CLKS), .CLK_W(CLK_W), .SKIP_W(SKIP_W),
                  .HOLD_W(HOLD_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .active_start(active_start), .hold(hold),
      .start_idx(start_idx), .start_phase(start_phase), .delay(delay),
      .len_q(len_q), .rd_data(rd_data), .rd_idx(rd_idx),
      .pix_out(pix_out), .de_out(de_out));
endmodule

// File: tb/scanline_player_bench.sv
module scanline_player_bench;
   localparam int LINE_PIX = 32;
   localparam int ACT_PIX  = 40;
   localparam int DIV      = 4;
   localparam int ACT_CLKS = ACT_PIX * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] desc_offset = '0;
   logic [7:0] desc_length = '0;
   logic [11:0] desc_stretch = '0;
   logic [9:0] desc_repeat = '0;
   logic       hblank_start = 1'b0;
   logic       active_start = 1'b0;
   logic [7:0] pix_out;
   logic       de_out;
   logic       gen_req;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   int work_m [LINE_PIX];
   int line_m [LINE_PIX];
   int off_m = 0, len_m = 0, str_m = 0, rpt_m = 0;
   int n_off = 0, n_len = 0, n_str = 0, n_rpt = 0;

   always #5 clk = ~clk;

   scanline_player u_scanline_player (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .desc_offset(desc_offset), .desc_length(desc_length),
      .desc_stretch(desc_stretch), .desc_repeat(desc_repeat),
      .hblank_start(hblank_start), .active_start(active_start),
      .pix_out(pix_out), .de_out(de_out), .gen_req(gen_req));

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < LINE_PIX; i++) begin
         work_m[i] = 0;
         line_m[i] = 0;
      end
      off_m = 0; len_m = 0; str_m = 0; rpt_m = 0;
   endtask

   task automatic fill_work(input int seed);
      for (int i = 0; i < LINE_PIX; i++) begin
         @(posedge clk); #1;
         wr_en = 1'b1;
         wr_addr = 5'(i);
         wr_data = 8'((seed + i * 13) % 255 + 1);
         work_m[i] = (seed + i * 13) % 255 + 1;
      end
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic set_desc(input int off, input int len, input int str, input int rpt);
      desc_offset = 8'(off); desc_length = 8'(len);
      desc_stretch = 12'(str); desc_repeat = 10'(rpt);
      n_off = off; n_len = len; n_str = str; n_rpt = rpt;
   endtask

   // model of a blanking strobe; checks the request pulse (R8)
   task automatic do_hblank(input string req);
      int exp_req;
      if (rpt_m == 0) begin
         for (int i = 0; i < LINE_PIX; i++) line_m[i] = work_m[i];
         off_m = n_off; len_m = (n_len > LINE_PIX) ? LINE_PIX : n_len;
         str_m = n_str; rpt_m = n_rpt; exp_req = 1;
      end else begin
         rpt_m--; exp_req = 0;
      end
      @(posedge clk); #1 hblank_start = 1'b1;
      @(posedge clk); #1 hblank_start = 1'b0;
      check({req, " R8 gen_req pulse"}, int'(gen_req), exp_req);
      @(posedge clk); #1;
      check({req, " R8 gen_req single cycle"}, int'(gen_req), 0);
      repeat (60) @(posedge clk);
   endtask

   function automatic int exp_pix(input int x);
      int hold, rel, i;
      hold = DIV + str_m;
      rel = x - off_m * DIV;
      if (rel < 0) return 0;
      i = rel / hold;
      if (i >= len_m) return 0;
      return line_m[i];
   endfunction

   // plays one active line and compares every clock (R4 R5 R6 R11)
   task automatic run_active(input string req);
      @(posedge clk); #1 active_start = 1'b1;
      @(posedge clk); #1 active_start = 1'b0;
      for (int k = 0; k < ACT_CLKS + 3; k++) begin
         @(posedge clk); #1;
         if (k < ACT_CLKS) begin
            check({req, " R11 de high"}, int'(de_out), 1);
            check({req, " pixel"}, int'(pix_out), exp_pix(k));
         end else begin
            check({req, " R11 de low after line"}, int'(de_out), 0);
            check({req, " R5 black after line"}, int'(pix_out), 0);
         end
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 pix_out reset", int'(pix_out), 0);
      check("R1 de_out reset", int'(de_out), 0);
      check("R1 gen_req reset", int'(gen_req), 0);
      run_active("R1 empty line");
   endtask

   task automatic t_basic();
      fill_work(3);
      set_desc(0, 32, 0, 0);
      do_hblank("R4 basic");
      run_active("R4 R5 R10 basic 4-clock pixels");
   endtask

   task automatic t_offset_stretch();
      fill_work(50);
      set_desc(5, 10, 3, 0);
      do_hblank("R4 offset");
      run_active("R4 R5 positive offset stretch 3");
   endtask

   task automatic t_negative();
      fill_work(90);
      set_desc(-3, 20, 2, 0);
      do_hblank("R6 neg");
      run_active("R6 offset -3 stretch 2");
      set_desc(-7, 32, 1, 0);
      do_hblank("R6 neg2");
      run_active("R6 offset -7 stretch 1");
   endtask

   task automatic t_isolation();
      fill_work(120);
      set_desc(0, 16, 4, 0);
      do_hblank("R2 iso");
      fill_work(7);
      set_desc(2, 5, 0, 0);
      desc_offset = 8'(2);
      run_active("R2 R3 old line kept");
      do_hblank("R3 iso next");
      run_active("R2 R3 new line applied");
   endtask

   task automatic t_repeat();
      fill_work(33);
      set_desc(1, 12, 6, 2);
      do_hblank("R7 first");
      fill_work(211);
      set_desc(0, 32, 0, 0);
      do_hblank("R7 replay 1");
      run_active("R7 replay 1 old line");
      do_hblank("R7 replay 2");
      run_active("R7 replay 2 old line");
      do_hblank("R7 fresh");
      run_active("R7 fresh line");
   endtask

   task automatic t_solid();
      fill_work(77);
      set_desc(0, 1, (ACT_PIX - 1) * DIV, 1000);
      do_hblank("R9 solid");
      run_active("R9 solid fill");
      check("R9 solid colour value", exp_pix(ACT_CLKS - 1), line_m[0]);
      do_hblank("R9 solid replay");
      run_active("R9 solid fill replay");
      do_reset();
   endtask

   initial begin
      t_reset();
      t_basic();
      t_offset_stretch();
      t_negative();
      t_isolation();
      t_repeat();
      t_solid();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule